// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Write-One Set/Clear Registers

This block is a register-mapped GPIO peripheral that serves several 32-pin banks from one register port. Each pin has four stored attributes: the level it drives, whether it drives at all, and whether a rising or a falling input transition is recorded. Software never rewrites an attribute word directly. It writes ones to a dedicated set register or a dedicated clear register, and reads the resulting state from a separate status register. Because of this, two agents can change different pins of one bank without a read-modify-write race.

Pin inputs are brought into the clock domain by a two-flop synchroniser. The synchronised value is compared with the previous sample to find edges. Enabled edges are latched in a sticky per-pin status word that software clears by writing ones. A per-pin unmask bit selects which latched edges reach the single interrupt line, which collects events from every bank.

The register port is a request stream that always accepts (`req_ready` is held high). A read request accepted on one clock edge returns its data on `rsp_valid`/`rsp_rdata` after the next edge. That response cannot be back-pressured, so the requester must take it in that cycle. Writes produce no response.

Top module: `gpio_mb_ctrl`

## Requirements
- R1: Register word for bank n of a group sits at the group base plus 4·n, with the low two address bits ignored. The group bases are: input level 0x00, drive-enable status 0x0C, drive-level set 0x18, drive-level clear 0x24, rise-enable status 0x30, fall-enable status 0x3C, edge status 0x48, drive-enable set 0x54, drive-enable clear 0x60, rise-enable set 0x6C, rise-enable clear 0x78, fall-enable set 0x84, fall-enable clear 0x90, unmask set 0x9C, unmask clear 0xA8. Pin p belongs to bank p>>5 at bit p&31, and maps to bit p of `pin_out`, `pin_oe` and `pin_in`.
- R2: A write to a drive-level set word ORs its data into that bank's stored levels, and a write to the clear word removes the data's one bits. Zero bits change nothing. The stored level appears on `pin_out` after the write's clock edge.
- R3: Drive-enable set and clear words change `pin_oe` in the same way, and drive-enable status reads back the stored enables. `pin_out` keeps its stored value while a pin is not driven.
- R4: Rise-enable and fall-enable are changed only through their set and clear words, and read back through their status words.
- R5: Every set and clear word reads as zero.
- R6: The level status word returns the pin input after two synchroniser flops. A pin change set up before clock edge k is first returned by a read accepted at edge k+2.
- R7: An edge status bit becomes 1 when the synchronised input goes 0→1 with rise enable set, or 1→0 with fall enable set. A transition whose direction is not enabled records nothing.
- R8: Edge status bits stay set until a 1 is written to them at the edge status word, and zero bits of that write have no effect. When an edge is detected on the same edge that its bit is cleared, the bit stays set.
- R9: `irq` is high exactly when some bank has a pin with both its edge status bit and its unmask bit set. After reset every pin is masked.
- R10: After reset all stored attributes and edge bits are zero, `pin_oe`, `pin_out`, `irq` and `rsp_valid` are low.
- R11: `req_ready` is always high. A read gives `rsp_valid` high with the data one cycle later, and `rsp_rdata` is zero when `rsp_valid` is low. A write never raises `rsp_valid`. An address beyond the last group changes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NUM_BANKS*32 (96) | Asynchronous pin inputs |
| pin_out | output | NUM_BANKS*32 (96) | Stored drive levels |
| pin_oe | output | NUM_BANKS*32 (96) | Drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
Edge capture and the write-one-to-clear of the edge status word can both fall on the same clock edge. One bank holds an old latched edge on one bit while a second pin is raised. The clear write, covering both bits, is timed to land on the third clock edge after the raise, which is the edge where the synchroniser delivers the new transition. A later read must show the old bit gone and the new bit kept, with `irq` still high because that bit is unmasked. A cycle-level behavioural model runs alongside and compares every output on each falling clock edge, through directed sequences and a pseudo-random phase of mixed accesses and pin toggles.

// File: rtl/gpio_mb_pkg.sv
`timescale 1ns/1ps
package gpio_mb_pkg;

  localparam int unsigned LANE_W      = 32;
  localparam int unsigned GROUP_COUNT = 15;

  // Group number = (byte address / 4) / slots-per-group.
  typedef enum logic [3:0] {
    G_LEVEL    = 4'd0,
    G_DIR      = 4'd1,
    G_OUT_SET  = 4'd2,
    G_OUT_CLR  = 4'd3,
    G_RISE     = 4'd4,
    G_FALL     = 4'd5,
    G_EDGE     = 4'd6,
    G_DIR_SET  = 4'd7,
    G_DIR_CLR  = 4'd8,
    G_RISE_SET = 4'd9,
    G_RISE_CLR = 4'd10,
    G_FALL_SET = 4'd11,
    G_FALL_CLR = 4'd12,
    G_UNM_SET  = 4'd13,
    G_UNM_CLR  = 4'd14,
    G_NONE     = 4'd15
  } grp_e;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic dir_set;
    logic dir_clr;
    logic rise_set;
    logic rise_clr;
    logic fall_set;
    logic fall_clr;
    logic unm_set;
    logic unm_clr;
    logic edge_w1c;
  } wr_strobe_t;

  typedef struct packed {
    logic [LANE_W-1:0] level;
    logic [LANE_W-1:0] dir;
    logic [LANE_W-1:0] rise;
    logic [LANE_W-1:0] fall;
    logic [LANE_W-1:0] edges;
  } bank_view_t;

  // Groups that hold no readable state.
  function automatic logic grp_write_only(grp_e g);
    return !(g inside {G_LEVEL, G_DIR, G_RISE, G_FALL, G_EDGE});
  endfunction

  function automatic logic [LANE_W-1:0] set_clr(logic [LANE_W-1:0] cur,
                                                logic [LANE_W-1:0] s,
                                                logic [LANE_W-1:0] c);
    return (cur | s) & ~c;
  endfunction

endpackage

// File: rtl/gpio_mb_sync.sv
`timescale 1ns/1ps
module gpio_mb_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_mb_decode.sv
`timescale 1ns/1ps
module gpio_mb_decode
  import gpio_mb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_BANKS    = 3,
  parameter int unsigned GROUP_STRIDE = 12,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 hit,
  output grp_e                 grp,
  output logic [IDX_W-1:0]     bank_idx,
  output logic [NUM_BANKS-1:0] bank_sel,
  output wr_strobe_t           stb
);

  localparam int unsigned SLOTS = GROUP_STRIDE / 4;

  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] grp_num;
  logic [ADDR_W-1:0] slot;
  logic              wr;

  always_comb begin
    word    = req_addr >> 2;
    grp_num = word / ADDR_W'(SLOTS);
    slot    = word % ADDR_W'(SLOTS);
  end

  assign hit      = (grp_num < ADDR_W'(GROUP_COUNT)) && (slot < ADDR_W'(NUM_BANKS));
  assign grp      = hit ? grp_e'(grp_num[3:0]) : G_NONE;
  assign bank_idx = slot[IDX_W-1:0];
  assign wr       = req_valid && req_write && hit;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign bank_sel[i] = hit && (slot == ADDR_W'(i));
  end

  always_comb begin
    stb          = '0;
    stb.out_set  = wr && (grp == G_OUT_SET);
    stb.out_clr  = wr && (grp == G_OUT_CLR);
    stb.dir_set  = wr && (grp == G_DIR_SET);
    stb.dir_clr  = wr && (grp == G_DIR_CLR);
    stb.rise_set = wr && (grp == G_RISE_SET);
    stb.rise_clr = wr && (grp == G_RISE_CLR);
    stb.fall_set = wr && (grp == G_FALL_SET);
    stb.fall_clr = wr && (grp == G_FALL_CLR);
    stb.unm_set  = wr && (grp == G_UNM_SET);
    stb.unm_clr  = wr && (grp == G_UNM_CLR);
    stb.edge_w1c = wr && (grp == G_EDGE);
  end

endmodule

// File: rtl/gpio_mb_bank.sv
`timescale 1ns/1ps
module gpio_mb_bank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  wr_strobe_t        stb,
  input  logic [LANE_W-1:0] wdata,
  input  logic [LANE_W-1:0] pin_async,
  output bank_view_t        view,
  output logic [LANE_W-1:0] pin_out,
  output logic [LANE_W-1:0] pin_oe,
  output logic              irq_out
);

  logic [LANE_W-1:0] level, prev_q;
  logic [LANE_W-1:0] out_q, dir_q, rise_q, fall_q, unm_q, edge_q;
  logic [LANE_W-1:0] out_s, out_c, dir_s, dir_c, rise_s, rise_c;
  logic [LANE_W-1:0] fall_s, fall_c, unm_s, unm_c, w1c;
  logic [LANE_W-1:0] rise_hit, fall_hit;

  gpio_mb_sync #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_async),
    .q    (level)
  );

  function automatic logic [LANE_W-1:0] pick(logic en, logic [LANE_W-1:0] d);
    return en ? d : '0;
  endfunction

  always_comb begin
    out_s  = pick(sel && stb.out_set,  wdata);
    out_c  = pick(sel && stb.out_clr,  wdata);
    dir_s  = pick(sel && stb.dir_set,  wdata);
    dir_c  = pick(sel && stb.dir_clr,  wdata);
    rise_s = pick(sel && stb.rise_set, wdata);
    rise_c = pick(sel && stb.rise_clr, wdata);
    fall_s = pick(sel && stb.fall_set, wdata);
    fall_c = pick(sel && stb.fall_clr, wdata);
    unm_s  = pick(sel && stb.unm_set,  wdata);
    unm_c  = pick(sel && stb.unm_clr,  wdata);
    w1c    = pick(sel && stb.edge_w1c, wdata);
    rise_hit = ~prev_q &  level & rise_q;
    fall_hit =  prev_q & ~level & fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      unm_q  <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= level;
      out_q  <= set_clr(out_q,  out_s,  out_c);
      dir_q  <= set_clr(dir_q,  dir_s,  dir_c);
      rise_q <= set_clr(rise_q, rise_s, rise_c);
      fall_q <= set_clr(fall_q, fall_s, fall_c);
      unm_q  <= set_clr(unm_q,  unm_s,  unm_c);
      // a freshly detected edge outranks a clear in the same cycle
      edge_q <= (edge_q & ~w1c) | rise_hit | fall_hit;
    end
  end

  assign view.level = level;
  assign view.dir   = dir_q;
  assign view.rise  = rise_q;
  assign view.fall  = fall_q;
  assign view.edges = edge_q;
  assign pin_out    = out_q;
  assign pin_oe     = dir_q;
  assign irq_out    = |(edge_q & unm_q);

  // R3: a drive-enable set write leaves every written one bit enabled
  p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && stb.dir_set) |=> ((dir_q & $past(wdata)) == $past(wdata)));

  // R2: drive levels only move on a level set or clear write to this bank
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (stb.out_set || stb.out_clr)) |=> $stable(out_q));

  // R8: latched edges survive every cycle without a clear write to this bank
  p_edge_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && stb.edge_w1c) |=> ((edge_q & $past(edge_q)) == $past(edge_q)));

  // R7: a newly latched edge needs one of its detect enables
  p_edge_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_q & ~$past(edge_q)) & ~($past(rise_q) | $past(fall_q))) == '0);

endmodule

// File: rtl/gpio_mb_ctrl.sv
`timescale 1ns/1ps
module gpio_mb_ctrl
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 3,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned GROUP_STRIDE = 12,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned NUM_PINS = NUM_BANKS * LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LANE_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [LANE_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                           dec_hit;
  grp_e                           dec_grp;
  logic [IDX_W-1:0]               dec_bank;
  logic [NUM_BANKS-1:0]           bank_sel;
  wr_strobe_t                     stb;
  bank_view_t [NUM_BANKS-1:0]     views;
  logic [NUM_BANKS-1:0]           bank_irq;
  logic [LANE_W-1:0]              rd_mux;
  logic                           rd_req;

  assign req_ready = 1'b1;
  assign rd_req    = req_valid && !req_write;

  gpio_mb_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_BANKS   (NUM_BANKS),
    .GROUP_STRIDE(GROUP_STRIDE)
  ) u_decode (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .hit      (dec_hit),
    .grp      (dec_grp),
    .bank_idx (dec_bank),
    .bank_sel (bank_sel),
    .stb      (stb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_mb_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel[b]),
      .stb      (stb),
      .wdata    (req_wdata),
      .pin_async(pin_in[b*LANE_W +: LANE_W]),
      .view     (views[b]),
      .pin_out  (pin_out[b*LANE_W +: LANE_W]),
      .pin_oe   (pin_oe[b*LANE_W +: LANE_W]),
      .irq_out  (bank_irq[b])
    );
  end

  assign irq = |bank_irq;

  always_comb begin
    rd_mux = '0;
    if (dec_hit) begin
      case (dec_grp)
        G_LEVEL: rd_mux = views[dec_bank].level;
        G_DIR:   rd_mux = views[dec_bank].dir;
        G_RISE:  rd_mux = views[dec_bank].rise;
        G_FALL:  rd_mux = views[dec_bank].fall;
        G_EDGE:  rd_mux = views[dec_bank].edges;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end

  // R11: a write never produces a response
  p_no_rsp_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  // R5: set and clear words return zero
  p_wo_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && grp_write_only(dec_grp)) |=> (rsp_valid && rsp_rdata == '0));

endmodule

// File: tb/gpio_mb_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_mb_ctrl_tb;

  localparam int NB = 3;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [7:0]    req_addr;
  logic [31:0]   req_wdata;
  logic          req_ready, rsp_valid, irq;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  gpio_mb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_out[NB], m_dir[NB], m_rise[NB], m_fall[NB], m_unm[NB], m_edge[NB];
  bit [31:0] m_s1[NB], m_s2[NB], m_prev[NB];
  bit        m_rsp_v;
  bit [31:0] m_rsp_d;

  function automatic bit [31:0] m_read(input logic [7:0] a);
    int w = int'(a) / 4;
    int g = w / 3;
    int b = w % 3;
    if (g > 14 || b >= NB) return 0;
    case (g)
      0: return m_s2[b];
      1: return m_dir[b];
      4: return m_rise[b];
      5: return m_fall[b];
      6: return m_edge[b];
      default: return 0;
    endcase
  endfunction

  function automatic bit m_irq();
    bit r = 0;
    for (int b = 0; b < NB; b++) r |= |(m_edge[b] & m_unm[b]);
    return r;
  endfunction

  always @(posedge clk) begin : model
    int g, b, w;
    bit [31:0] w1c[NB];
    bit [31:0] ne[NB];
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_out[i] = 0; m_dir[i] = 0; m_rise[i] = 0; m_fall[i] = 0; m_unm[i] = 0;
        m_edge[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
      end
      m_rsp_v = 0; m_rsp_d = 0;
    end else begin
      m_rsp_v = req_valid && !req_write;
      m_rsp_d = m_rsp_v ? m_read(req_addr) : 32'h0;
      for (int i = 0; i < NB; i++) begin
        w1c[i] = 0;
        ne[i] = (~m_prev[i] & m_s2[i] & m_rise[i]) | (m_prev[i] & ~m_s2[i] & m_fall[i]);
      end
      if (req_valid && req_write) begin
        w = int'(req_addr) / 4; g = w / 3; b = w % 3;
        if (g <= 14 && b < NB) begin
          case (g)
            2:  m_out[b]  |= req_wdata;
            3:  m_out[b]  &= ~req_wdata;
            6:  w1c[b]     = req_wdata;
            7:  m_dir[b]  |= req_wdata;
            8:  m_dir[b]  &= ~req_wdata;
            9:  m_rise[b] |= req_wdata;
            10: m_rise[b] &= ~req_wdata;
            11: m_fall[b] |= req_wdata;
            12: m_fall[b] &= ~req_wdata;
            13: m_unm[b]  |= req_wdata;
            14: m_unm[b]  &= ~req_wdata;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NB; i++) begin
        m_edge[i] = (m_edge[i] & ~w1c[i]) | ne[i];
        m_prev[i] = m_s2[i];
        m_s2[i]   = m_s1[i];
        m_s1[i]   = pin_in[i*32 +: 32];
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin : cmp
    logic [NP-1:0] eo, eoe;
    if (rst_n && !done) begin
      for (int b = 0; b < NB; b++) begin
        eo[b*32 +: 32]  = m_out[b];
        eoe[b*32 +: 32] = m_dir[b];
      end
      check(pin_out === eo, "R2 pin_out vs model", pin_out, eo);
      check(pin_oe === eoe, "R3 pin_oe vs model", pin_oe, eoe);
      check(irq === m_irq(), "R9 irq vs model", irq, m_irq());
      check(rsp_valid === m_rsp_v, "R11 rsp_valid vs model", rsp_valid, m_rsp_v);
      check(rsp_rdata === m_rsp_d, "R1 rsp_rdata vs model", rsp_rdata, m_rsp_d);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1 && rsp_rdata === exp, tag, rsp_rdata, exp);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog R11: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lf;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; pin_in = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R10 reset state
    check(pin_oe === '0, "R10 pin_oe after reset", pin_oe, '0);
    check(pin_out === '0, "R10 pin_out after reset", pin_out, '0);
    check(irq === 1'b0, "R10 irq after reset", irq, 0);
    check(rsp_valid === 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
    rd(8'h48, 32'h0, "R10 edge status after reset");

    // R2 / R3 drive level and enable
    wr(8'h18, 32'h0000_00A5);
    wr(8'h54, 32'h0000_00FF);
    check(pin_out[31:0] === 32'hA5, "R2 level set bank0", pin_out[31:0], 32'hA5);
    check(pin_oe[31:0] === 32'hFF, "R3 enable set bank0", pin_oe[31:0], 32'hFF);

    // R1 interleaved bank addressing
    wr(8'h1C, 32'h1234_0000);
    wr(8'h20, 32'h8000_0001);
    check(pin_out === {32'h8000_0001, 32'h1234_0000, 32'h0000_00A5},
          "R1 bank interleave", pin_out, {32'h8000_0001, 32'h1234_0000, 32'h0000_00A5});

    wr(8'h24, 32'h0000_0005);
    check(pin_out[31:0] === 32'hA0, "R2 level clear bank0", pin_out[31:0], 32'hA0);
    wr(8'h60, 32'h0000_00F0);
    check(pin_oe[31:0] === 32'h0F, "R3 enable clear bank0", pin_oe[31:0], 32'h0F);
    check(pin_out[31:0] === 32'hA0, "R3 level held while undriven", pin_out[31:0], 32'hA0);
    rd(8'h0C, 32'h0000_000F, "R3 enable status bank0");
    rd(8'h10, 32'h0, "R3 enable status bank1");

    // R5 write-only words read zero
    rd(8'h18, 32'h0, "R5 level set reads zero");
    rd(8'h54, 32'h0, "R5 enable set reads zero");
    rd(8'h9C, 32'h0, "R5 unmask set reads zero");

    // R4 detect enables
    wr(8'h70, 32'h0000_0100);
    wr(8'h8C, 32'h0000_0002);
    rd(8'h34, 32'h0000_0100, "R4 rise enable bank1");
    rd(8'h44, 32'h0000_0002, "R4 fall enable bank2");

    // R6 synchroniser latency, then R7 edge capture
    pin_in[40] = 1'b1;
    rd(8'h04, 32'h0, "R6 level at edge k");
    rd(8'h04, 32'h0, "R6 level at edge k+1");
    rd(8'h04, 32'h0000_0100, "R6 level at edge k+2");
    rd(8'h4C, 32'h0000_0100, "R7 rising edge latched bank1");
    check(irq === 1'b0, "R9 masked edge keeps irq low", irq, 0);

    wr(8'hA0, 32'h0000_0100);
    check(irq === 1'b1, "R9 unmask raises irq", irq, 1);

    // R8 sticky and write-one-to-clear
    wr(8'h4C, 32'h0);
    check(irq === 1'b1, "R8 zero write keeps edge", irq, 1);
    rd(8'h4C, 32'h0000_0100, "R8 edge still set");
    wr(8'h4C, 32'h0000_0100);
    check(irq === 1'b0, "R8 clear drops irq", irq, 0);
    rd(8'h4C, 32'h0, "R8 edge cleared");

    // R7 direction filter on bank2 bit1 (pin 65)
    pin_in[65] = 1'b1;
    repeat (4) tick();
    rd(8'h50, 32'h0, "R7 rise ignored with only fall enabled");
    pin_in[65] = 1'b0;
    repeat (4) tick();
    rd(8'h50, 32'h0000_0002, "R7 falling edge latched bank2");
    check(irq === 1'b0, "R9 bank2 masked", irq, 0);
    wr(8'hA4, 32'h0000_0002);
    check(irq === 1'b1, "R9 bank2 unmasked", irq, 1);
    wr(8'hB0, 32'h0000_0002);
    check(irq === 1'b0, "R9 mask clear drops irq", irq, 0);
    rd(8'h50, 32'h0000_0002, "R9 masking keeps edge status");
    wr(8'h50, 32'h0000_0002);

    // R8 edge detected in the same cycle as its clear
    pin_in[40] = 1'b0;
    repeat (4) tick();
    wr(8'h70, 32'h0000_0200);
    pin_in[41] = 1'b1;
    repeat (4) tick();
    rd(8'h4C, 32'h0000_0200, "R8 old edge present");
    pin_in[40] = 1'b1;
    tick();
    tick();
    wr(8'h4C, 32'h0000_0300);
    rd(8'h4C, 32'h0000_0100, "R8 new edge outranks clear");
    check(irq === 1'b1, "R9 irq from surviving edge", irq, 1);

    // R11 port rules and out-of-map addresses
    check(req_ready === 1'b1, "R11 ready always high", req_ready, 1);
    wr(8'hB4, 32'hFFFF_FFFF);
    check(rsp_valid === 1'b0, "R11 no response to write", rsp_valid, 0);
    check(pin_out === {32'h8000_0001, 32'h1234_0000, 32'h0000_00A0},
          "R11 out-of-map write ignored", pin_out,
          {32'h8000_0001, 32'h1234_0000, 32'h0000_00A0});
    check(pin_oe === {64'h0, 32'h0000_000F}, "R11 out-of-map enables intact",
          pin_oe, {64'h0, 32'h0000_000F});
    rd(8'hB4, 32'h0, "R11 out-of-map read zero");
    rd(8'hFC, 32'h0, "R11 top address read zero");
    tick();
    check(rsp_valid === 1'b0 && rsp_rdata === 32'h0, "R11 idle response zero", rsp_rdata, 0);
    wr(8'h4C, 32'hFFFF_FFFF);

    // pseudo-random phase, judged by the per-cycle model comparison
    lf = 32'h1D87_2B41;
    for (int i = 0; i < 600; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      if (lf[0]) pin_in[int'(lf[14:8]) % NP] = ~pin_in[int'(lf[14:8]) % NP];
      req_valid = lf[2];
      req_write = lf[3];
      req_addr  = (lf[4] ? lf[23:16] : {lf[23:18] % 6'd45, lf[17:16]});
      req_wdata = lf ^ {lf[15:0], lf[31:16]};
      tick();
    end
    req_valid = 0; req_write = 0;
    repeat (4) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule